// File: doc/BRIEF.md
# Cluster Control Register File

This block is the shared control register file of a small multi-core cluster. Every access on its 64-bit register bus carries the index of the core that issued it. A global page holds registers common to the whole cluster. Each core also owns a private slot with a configuration word, an "other" selector and a reset-vector base. A core reaches its own slot through the local page. It reaches a second core's slot through the other page, and its own selector names that second core. Through this indirection one core can prepare the boot vector of another core before that core is released.

The global page holds two relocatable base registers. Each one places an attached sub-region, such as an interrupt controller or a power controller, and switches it on or off. The block drives the decode base and the enable of each sub-region from these registers. A parameter says whether each sub-region is present, and a status word reports it. Each core receives a sign-extended exception base that is derived from its reset-vector register. All reads are registered and return one cycle after the request.

Top module: `cluster_ctl_regs`

## Requirements
- R1: An access in the local page (byte offsets 0x2000 to 0x2FFF) reaches the private slot of the core given on `core_id_i`. The slot offsets are 0x010 for config, 0x020 for the selector and 0x030 for the reset base. The slots of other cores are not touched.
- R2: An access in the other page (0x4000 to 0x4FFF, same slot offsets) reaches the slot of the core named by the requesting core's own selector.
- R3: A read of the config word, through either page, returns NCORES-1.
- R4: Every selector resets to 0. A selector write through either page compares the low 4 bits of the write data with NCORES. If the value is less than NCORES it is stored. Otherwise the write is dropped and the selector keeps its value.
- R5: Each reset-base register resets to 0xBFC00000. A write stores the data ANDed with 0x00000000_FFFFF003, and a read returns the stored value.
- R6: `exc_base_o` of each core is bits 31:12 of its reset-base register, with bits 11:0 cleared, sign-extended from bit 31 to 64 bits. It is valid from the cycle after the write.
- R7: The sub-region base registers sit at 0x008 (interrupt) and 0x010 (power). A write stores the data ANDed with 0xFFFFFFFF_FFFF8001. From the next cycle, the base output shows bits 63:15 with the low bits cleared, and the enable output shows bit 0. Both registers reset to 0, so both sub-regions start disabled.
- R8: A write to the base register of an absent sub-region is ignored, and that register reads 0. The status words at 0x018 (interrupt) and 0x020 (power) read 1 when the sub-region is present and 0 when it is absent.
- R9: The word at 0x028 is read-only and always returns 0x00100000, the bypass flag in bit 20. Writes to it change nothing.
- R10: A read request sets `rvalid_o` and `rdata_o` on the next clock edge. `rdata_o` holds its value while no read is issued. Unmapped offsets read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| core_id_i | input | CID_W | Index of the requesting core |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 64 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 64 | Registered read data |
| irq_base_o | output | 64 | Interrupt sub-region decode base |
| irq_en_o | output | 1 | Interrupt sub-region enable |
| pwr_base_o | output | 64 | Power sub-region decode base |
| pwr_en_o | output | 1 | Power sub-region enable |
| exc_base_o | output | NCORES*64 | Per-core exception base, core k in bits 64k+63:64k |

## Verification
Read data and `rvalid_o` come from a single register, so each result is due at the first clock edge after the request cycle. The monitor samples it at the following falling edge and compares it with the item the driver queued for that request. State outputs (`exc_base_o`, the sub-region base and enable) also change at the edge that takes the write. They are checked at the falling edge right after that edge. Every dropped write is followed by a readback of the target register or by a check of the output it could have changed.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int SEL_FIELD_W = 4;

  localparam logic [3:0] PAGE_GLOBAL = 4'h0;
  localparam logic [3:0] PAGE_LOCAL  = 4'h2;
  localparam logic [3:0] PAGE_OTHER  = 4'h4;

  localparam logic [11:0] OFS_IRQ_BASE = 12'h008;
  localparam logic [11:0] OFS_PWR_BASE = 12'h010;
  localparam logic [11:0] OFS_IRQ_STAT = 12'h018;
  localparam logic [11:0] OFS_PWR_STAT = 12'h020;
  localparam logic [11:0] OFS_L2_CFG   = 12'h028;

  localparam logic [11:0] OFS_CFG = 12'h010;
  localparam logic [11:0] OFS_SEL = 12'h020;
  localparam logic [11:0] OFS_RB  = 12'h030;

  localparam logic [63:0] SUB_MASK      = 64'hFFFF_FFFF_FFFF_8001;
  localparam logic [63:0] SUB_BASE_MASK = 64'hFFFF_FFFF_FFFF_8000;
  localparam logic [63:0] RB_MASK       = 64'h0000_0000_FFFF_F003;
  localparam logic [31:0] RB_FIELD      = 32'hFFFF_F000;
  localparam logic [63:0] RB_RESET      = 64'h0000_0000_BFC0_0000;
  localparam logic [63:0] L2_VALUE      = 64'h0000_0000_0010_0000;

  typedef enum logic [1:0] {WIN_NONE, WIN_GLOBAL, WIN_LOCAL, WIN_OTHER} win_e;

  typedef struct packed {
    win_e        win;
    logic [11:0] ofs;
  } dec_t;
endpackage

// File: rtl/ccr_subregion.sv
module ccr_subregion
  import ccr_pkg::*;
#(
  parameter bit PRESENT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] reg_o,
  output logic [63:0] base_o,
  output logic        en_o
);
  logic [63:0] q;

  generate
    if (PRESENT) begin : g_present
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (we_i) q <= wdata_i & SUB_MASK;
      end
    end else begin : g_absent
      assign q = '0;
    end
  endgenerate

  // base and enable move together from one register
  assign reg_o  = q;
  assign base_o = q & SUB_BASE_MASK;
  assign en_o   = q[0];

  a_r7_en_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_o));
  a_r7_base_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(base_o));
endmodule

// File: rtl/ccr_core_slot.sv
module ccr_core_slot
  import ccr_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int CID_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic             rb_we_i,
  input  logic [63:0]      wdata_i,
  output logic [CID_W-1:0] sel_o,
  output logic [63:0]      rb_o,
  output logic [63:0]      exc_base_o
);
  logic [SEL_FIELD_W-1:0] sel_field;
  logic                   sel_ok;
  logic [CID_W-1:0]       sel_q;
  logic [63:0]            rb_q;
  logic [31:0]            base_field;

  assign sel_field = wdata_i[SEL_FIELD_W-1:0];
  assign sel_ok    = 32'(sel_field) < NCORES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      rb_q  <= RB_RESET & RB_MASK;
    end else begin
      if (sel_we_i && sel_ok) sel_q <= CID_W'(sel_field);
      if (rb_we_i)            rb_q  <= wdata_i & RB_MASK;
    end
  end

  assign sel_o      = sel_q;
  assign rb_o       = rb_q;
  assign base_field = rb_q[31:0] & RB_FIELD;
  assign exc_base_o = {{32{base_field[31]}}, base_field};

  a_r4_sel_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sel_o) < NCORES);
  a_r4_drop_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && 32'(wdata_i[SEL_FIELD_W-1:0]) >= NCORES) |=> $stable(sel_o));
  a_r6_exc_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rb_we_i |=> $stable(exc_base_o));
endmodule

// File: rtl/cluster_ctl_regs.sv
module cluster_ctl_regs
  import ccr_pkg::*;
#(
  parameter int NCORES      = 4,
  parameter int ADDR_W      = 16,
  parameter bit IRQ_PRESENT = 1'b1,
  parameter bit PWR_PRESENT = 1'b1,
  localparam int CID_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [CID_W-1:0]       core_id_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [63:0]            wdata_i,
  output logic                   rvalid_o,
  output logic [63:0]            rdata_o,
  output logic [63:0]            irq_base_o,
  output logic                   irq_en_o,
  output logic [63:0]            pwr_base_o,
  output logic                   pwr_en_o,
  output logic [NCORES-1:0][63:0] exc_base_o
);
  localparam int PAGE_W = ADDR_W - 12;

  dec_t              dec;
  logic              id_ok;
  logic              wr, rd;
  logic [CID_W-1:0]  own_sel;
  logic [CID_W-1:0]  tgt;
  logic              slot_hit;
  logic [CID_W-1:0]  sel_q [NCORES];
  logic [63:0]       rb_q  [NCORES];
  logic [63:0]       irq_reg, pwr_reg;
  logic [63:0]       rd_val;

  assign wr    = req_i && we_i;
  assign rd    = req_i && !we_i;
  assign id_ok = 32'(core_id_i) < NCORES;

  always_comb begin
    dec.ofs = addr_i[11:0];
    dec.win = WIN_NONE;
    if (addr_i[ADDR_W-1:12] == PAGE_W'(PAGE_GLOBAL))     dec.win = WIN_GLOBAL;
    else if (addr_i[ADDR_W-1:12] == PAGE_W'(PAGE_LOCAL)) dec.win = WIN_LOCAL;
    else if (addr_i[ADDR_W-1:12] == PAGE_W'(PAGE_OTHER)) dec.win = WIN_OTHER;
  end

  always_comb begin
    own_sel = '0;
    for (int k = 0; k < NCORES; k++)
      if (32'(core_id_i) == k) own_sel = sel_q[k];
  end

  assign tgt      = (dec.win == WIN_OTHER) ? own_sel : core_id_i;
  assign slot_hit = id_ok && (dec.win == WIN_LOCAL || dec.win == WIN_OTHER);

  generate
    for (genvar k = 0; k < NCORES; k++) begin : g_core
      logic sel_we, rb_we;
      assign sel_we = wr && slot_hit && dec.ofs == OFS_SEL && 32'(tgt) == k;
      assign rb_we  = wr && slot_hit && dec.ofs == OFS_RB  && 32'(tgt) == k;

      ccr_core_slot #(.NCORES(NCORES), .CID_W(CID_W)) u_slot (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_we_i   (sel_we),
        .rb_we_i    (rb_we),
        .wdata_i    (wdata_i),
        .sel_o      (sel_q[k]),
        .rb_o       (rb_q[k]),
        .exc_base_o (exc_base_o[k])
      );
    end
  endgenerate

  ccr_subregion #(.PRESENT(IRQ_PRESENT)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr && dec.win == WIN_GLOBAL && dec.ofs == OFS_IRQ_BASE),
    .wdata_i (wdata_i),
    .reg_o   (irq_reg),
    .base_o  (irq_base_o),
    .en_o    (irq_en_o)
  );

  ccr_subregion #(.PRESENT(PWR_PRESENT)) u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr && dec.win == WIN_GLOBAL && dec.ofs == OFS_PWR_BASE),
    .wdata_i (wdata_i),
    .reg_o   (pwr_reg),
    .base_o  (pwr_base_o),
    .en_o    (pwr_en_o)
  );

  always_comb begin
    rd_val = '0;
    if (dec.win == WIN_GLOBAL) begin
      unique case (dec.ofs)
        OFS_IRQ_BASE: rd_val = irq_reg;
        OFS_PWR_BASE: rd_val = pwr_reg;
        OFS_IRQ_STAT: rd_val = 64'(IRQ_PRESENT);
        OFS_PWR_STAT: rd_val = 64'(PWR_PRESENT);
        OFS_L2_CFG:   rd_val = L2_VALUE;
        default:      rd_val = '0;
      endcase
    end else if (slot_hit) begin
      for (int k = 0; k < NCORES; k++) begin
        if (32'(tgt) == k) begin
          unique case (dec.ofs)
            OFS_CFG: rd_val = 64'(NCORES - 1);
            OFS_SEL: rd_val = 64'(sel_q[k]);
            OFS_RB:  rd_val = rb_q[k];
            default: rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_val;
    end
  end

  a_r10_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  a_r10_no_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  a_r2_sel_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(own_sel) < NCORES);
endmodule

// File: tb/cluster_ctl_regs_test.sv
module cluster_ctl_regs_test;
  localparam int NC = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [CW-1:0] cid = '0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0;
  logic rvalid;
  logic [63:0] rdata, irq_base, pwr_base;
  logic irq_en, pwr_en;
  logic [NC-1:0][63:0] exc;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [63:0] exp; string tag; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  cluster_ctl_regs #(.NCORES(NC), .ADDR_W(16), .IRQ_PRESENT(1'b1), .PWR_PRESENT(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .core_id_i(cid),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata),
    .irq_base_o(irq_base), .irq_en_o(irq_en), .pwr_base_o(pwr_base),
    .pwr_en_o(pwr_en), .exc_base_o(exc)
  );

  function automatic logic [63:0] sx(logic [63:0] rb);
    logic [31:0] f;
    f = rb[31:0] & 32'hFFFF_F000;
    return {{32{f[31]}}, f};
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(int c, logic [15:0] a, logic [63:0] d);
    req = 1; we = 1; cid = CW'(c); addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic rd(int c, logic [15:0] a, logic [63:0] exp, string tag);
    item_t it;
    req = 1; we = 0; cid = CW'(c); addr = a; wdata = '0;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle();
    req = 0; we = 0;
    @(negedge clk);
  endtask

  // monitor: result due one edge after the request
  always @(negedge clk) begin
    if (rst_ni && rvalid) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected rvalid got %h exp none", rdata);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int c = 0; c < NC; c++) chk("R6 reset exc base", exc[c], 64'hFFFF_FFFF_BFC0_0000);
    chk("R7 reset irq en", {63'd0, irq_en}, 64'd0);
    chk("R7 reset irq base", irq_base, 64'd0);
    chk("R10 reset rvalid", {63'd0, rvalid}, 64'd0);

    rd(0, 16'h2030, 64'hBFC0_0000, "R5 reset rb");
    rd(2, 16'h2010, 64'd3, "R3 local cfg");
    rd(1, 16'h4010, 64'd3, "R3 other cfg");
    rd(1, 16'h2020, 64'd0, "R4 reset sel");
    idle();

    wr(0, 16'h2030, 64'h0000_0000_1234_5FFF);
    chk("R6 exc core0", exc[0], 64'h0000_0000_1234_5000);
    chk("R1 exc core1 untouched", exc[1], 64'hFFFF_FFFF_BFC0_0000);
    rd(0, 16'h2030, 64'h1234_5003, "R5 masked rb");
    rd(1, 16'h2030, 64'hBFC0_0000, "R1 other slot untouched");

    wr(0, 16'h2020, 64'd2);
    rd(0, 16'h2020, 64'd2, "R4 sel accepted");
    wr(0, 16'h4030, 64'h0000_0000_8000_1234);
    chk("R2 exc core2 via other", exc[2], sx(64'h8000_1234 & 64'hFFFF_F003));
    chk("R2 exc core0 untouched", exc[0], 64'h0000_0000_1234_5000);
    rd(2, 16'h2030, 64'h8000_1000, "R2 rb via other");
    rd(0, 16'h4030, 64'h8000_1000, "R2 other read");

    wr(0, 16'h2020, 64'd5);
    rd(0, 16'h2020, 64'd2, "R4 drop 5");
    wr(0, 16'h2020, 64'h13);
    rd(0, 16'h2020, 64'd3, "R4 masked 0x13");
    wr(0, 16'h2020, 64'd4);
    rd(0, 16'h2020, 64'd3, "R4 drop 4");

    wr(0, 16'h4020, 64'd1);
    rd(3, 16'h2020, 64'd1, "R4 sel via other");
    rd(0, 16'h4020, 64'd1, "R2 other sel read");
    wr(0, 16'h4020, 64'd9);
    rd(3, 16'h2020, 64'd1, "R4 other drop 9");
    idle();

    wr(0, 16'h0008, 64'h0000_0001_2345_FFFF);
    chk("R7 irq base", irq_base, 64'h0000_0001_2345_8000);
    chk("R7 irq en", {63'd0, irq_en}, 64'd1);
    rd(0, 16'h0008, 64'h0000_0001_2345_8001, "R7 irq readback");
    wr(1, 16'h0008, 64'h0000_0000_0001_0000);
    chk("R7 irq disable", {63'd0, irq_en}, 64'd0);
    chk("R7 irq base moved", irq_base, 64'h0000_0000_0001_0000);

    wr(0, 16'h0010, 64'h0000_0000_0000_8001);
    chk("R8 pwr en absent", {63'd0, pwr_en}, 64'd0);
    chk("R8 pwr base absent", pwr_base, 64'd0);
    rd(0, 16'h0010, 64'd0, "R8 pwr readback");
    rd(0, 16'h0018, 64'd1, "R8 irq status");
    rd(0, 16'h0020, 64'd0, "R8 pwr status");

    rd(0, 16'h0028, 64'h0010_0000, "R9 l2 cfg");
    wr(0, 16'h0028, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(0, 16'h0028, 64'h0010_0000, "R9 l2 after write");

    rd(0, 16'h00F8, 64'd0, "R10 unmapped global");
    rd(2, 16'h2040, 64'd0, "R10 unmapped slot");
    wr(0, 16'h2048, 64'hDEAD_BEEF);
    wr(0, 16'h6030, 64'hDEAD_BEEF);
    chk("R10 unmapped write exc0", exc[0], 64'h0000_0000_1234_5000);
    rd(0, 16'h2030, 64'h1234_5003, "R10 rb after unmapped write");
    idle();
    chk("R10 rdata hold", rdata, 64'h1234_5003);
    chk("R10 rvalid idle", {63'd0, rvalid}, 64'd0);
    idle();

    chk("R10 queue drained", 64'(q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule